// File: doc/BRIEF.md
# Semi-Digital Hit Memory with Timestamp

This block sits behind the discriminators of a 64-channel self-triggered front end. Each channel delivers three comparator outputs whose thresholds rise roughly by a decade each. Acquisition takes place while `acq_on` is high. In that window, every bunch-crossing cycle with `trig_valid` high turns the 192 comparator bits into a 2-bit level per channel. It writes one frame into an on-chip store that holds up to 128 frames. A frame is the 128 level bits plus the value of a bunch-crossing counter.

When `acq_on` falls, the idle gap begins and the stored frames can be read out. Readout runs on its own clock and uses a chain of chips that pass a token. A chip that receives the token sends all its frames serially as a valid/ready bit stream, then hands the token to the next chip. A chip with nothing stored hands the token on at once. The serial output honours back-pressure. While `sout_valid` is high and `sout_ready` is low, the current bit is held, and no bit is lost or repeated. A bit is consumed on each readout clock edge where both are high.

Top module: `semi_digital_hitmem`

## Requirements
- R1: For channel c, the comparator bits are `disc[3c]` (lowest threshold), `disc[3c+1]` and `disc[3c+2]` (highest). The level code is 3 when bit 3c+2 is set, otherwise 2 when bit 3c+1 is set, otherwise 1 when bit 3c is set, otherwise 0. This also maps non-monotonic patterns to the highest threshold crossed.
- R2: Each frame is sent most significant bit first: the timestamp first, then the level code of channel 63 down to channel 0, each code high bit first. A frame is TSW+128 bits long.
- R3: The timestamp counter is 0 on the first `bx_clk` edge at which `acq_on` is high. It rises by one on every later edge of the window and wraps to 0 after 2^TSW-1. A frame carries the counter value of the edge that stored it.
- R4: A frame is stored only on a `bx_clk` edge where both `acq_on` and `trig_valid` are high. The frame count restarts from zero when a new window opens, which also clears `mem_full`.
- R5: After 128 frames are stored, `mem_full` is high and later triggers in the same window are dropped.
- R6: While a window is open, `sout_valid` stays low and `token_in` is ignored.
- R7: While `sout_valid` is high and `sout_ready` is low, `sout` and `sout_valid` hold their values.
- R8: On `token_in` in the idle gap, a chip with stored frames streams them in order of storage. `token_out` is then high for one `ro_clk` cycle, starting at the edge that consumes the final bit.
- R9: On `token_in` in the idle gap, a chip with no unread frames raises `token_out` for one cycle at the `ro_clk` edge that samples `token_in`, and sends no data.
- R10: After reset, `sout_valid`, `token_out` and `mem_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bx_clk | input | 1 | Bunch-crossing clock for acquisition |
| ro_clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| acq_on | input | 1 | Acquisition window open (bx_clk domain) |
| disc | input | 192 | Comparator outputs, three per channel |
| trig_valid | input | 1 | Store a frame this bunch crossing |
| token_in | input | 1 | One-cycle token pulse from the previous chip (ro_clk domain) |
| sout_ready | input | 1 | Downstream accepts the current serial bit |
| sout | output | 1 | Serial frame data |
| sout_valid | output | 1 | Serial bit is valid |
| token_out | output | 1 | One-cycle token pulse to the next chip |
| mem_full | output | 1 | Frame store holds 128 frames |

## Verification
The readout checks assume that `acq_on` changes only between windows, with several `ro_clk` cycles of idle before the first token. They also assume that `token_in` arrives as a one-cycle pulse while the chip is not streaming. Under these conditions the frame count read across domains is stable. The stimulus opens and closes windows from the bunch-crossing side and waits for the synchronised idle before pulsing the token. It holds `sout_ready` at random only from the consumer side, so the stall rule is exercised on many bits of every frame.

// File: rtl/hm_pkg.sv
package hm_pkg;
  typedef enum logic {RD_IDLE, RD_SHIFT} rd_state_e;

  function automatic logic [1:0] level_code(input logic [2:0] d);
    if (d[2])      return 2'd3;
    else if (d[1]) return 2'd2;
    else if (d[0]) return 2'd1;
    else           return 2'd0;
  endfunction
endpackage

// File: rtl/hm_encoder.sv
module hm_encoder #(
  parameter int NCH = 64
) (
  input  logic [3*NCH-1:0] disc,
  output logic [2*NCH-1:0] codes
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign codes[2*c +: 2] = hm_pkg::level_code(disc[3*c +: 3]);
  end
endmodule

// File: rtl/hm_frame_store.sv
module hm_frame_store #(
  parameter int NCH   = 64,
  parameter int DEPTH = 128,
  parameter int TSW   = 24,
  localparam int FW   = TSW + 2*NCH,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic           bx_clk,
  input  logic           rst_n,
  input  logic           acq_on,
  input  logic           trig_valid,
  input  logic [2*NCH-1:0] codes,
  input  logic [AW-1:0]  rd_addr,
  output logic [FW-1:0]  rd_data,
  output logic [CW-1:0]  wr_cnt,
  output logic           mem_full
);
  logic [TSW-1:0] ts;
  logic           acq_q;
  logic [FW-1:0]  mem [DEPTH];

  wire          rise  = acq_on & ~acq_q;
  wire          we    = acq_on & trig_valid & (rise | ~mem_full);
  wire [AW-1:0] waddr = rise ? '0 : wr_cnt[AW-1:0];

  assign mem_full = (wr_cnt == CW'(DEPTH));
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge bx_clk or negedge rst_n) begin
    if (!rst_n) begin
      ts     <= '0;
      acq_q  <= 1'b0;
      wr_cnt <= '0;
    end else begin
      acq_q <= acq_on;
      ts    <= acq_on ? ts + 1'b1 : '0;
      if (rise)    wr_cnt <= CW'(we);
      else if (we) wr_cnt <= wr_cnt + 1'b1;
    end
  end

  always_ff @(posedge bx_clk) begin
    if (we) mem[waddr] <= {ts, codes};
  end

  p_ts_step_r3: assert property (@(posedge bx_clk) disable iff (!rst_n)
    acq_on |=> (ts == $past(ts) + 1'b1));
  p_no_overflow_r5: assert property (@(posedge bx_clk) disable iff (!rst_n)
    wr_cnt <= CW'(DEPTH));
  p_drop_when_full_r5: assert property (@(posedge bx_clk) disable iff (!rst_n)
    (acq_on && acq_q && mem_full) |=> (wr_cnt == $past(wr_cnt)));
endmodule

// File: rtl/hm_token_reader.sv
module hm_token_reader #(
  parameter int FW    = 152,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH+1),
  localparam int BW   = $clog2(FW)
) (
  input  logic          ro_clk,
  input  logic          rst_n,
  input  logic          acq_on,
  input  logic          token_in,
  input  logic          sout_ready,
  input  logic [CW-1:0] wr_cnt,
  input  logic [FW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          sout,
  output logic          sout_valid,
  output logic          token_out
);
  import hm_pkg::*;

  rd_state_e     state;
  logic          acq_m, acq_s;
  logic [CW-1:0] rd_ptr;
  logic [BW-1:0] bit_cnt;
  logic [FW-1:0] sh;

  wire [CW-1:0] nxt_ptr = rd_ptr + 1'b1;
  wire          empty   = (rd_ptr == wr_cnt);
  wire          last    = (nxt_ptr == wr_cnt);

  assign rd_addr    = (state == RD_IDLE) ? rd_ptr[AW-1:0] : nxt_ptr[AW-1:0];
  assign sout       = sh[FW-1];
  assign sout_valid = (state == RD_SHIFT);

  always_ff @(posedge ro_clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_m     <= 1'b0;
      acq_s     <= 1'b0;
      state     <= RD_IDLE;
      rd_ptr    <= '0;
      bit_cnt   <= '0;
      sh        <= '0;
      token_out <= 1'b0;
    end else begin
      acq_m     <= acq_on;
      acq_s     <= acq_m;
      token_out <= 1'b0;
      if (acq_s) begin
        state  <= RD_IDLE;
        rd_ptr <= '0;
      end else if (state == RD_IDLE) begin
        if (token_in) begin
          if (empty) token_out <= 1'b1;
          else begin
            state   <= RD_SHIFT;
            sh      <= rd_data;
            bit_cnt <= '0;
          end
        end
      end else if (sout_ready) begin
        if (bit_cnt == BW'(FW-1)) begin
          bit_cnt <= '0;
          rd_ptr  <= nxt_ptr;
          if (last) begin
            state     <= RD_IDLE;
            token_out <= 1'b1;
          end else begin
            sh <= rd_data;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          sh      <= {sh[FW-2:0], 1'b0};
        end
      end
    end
  end

  p_stall_hold_r7: assert property (@(posedge ro_clk) disable iff (!rst_n)
    (sout_valid && !sout_ready && !acq_s) |=> (sout_valid && $stable(sout)));
  p_quiet_window_r6: assert property (@(posedge ro_clk) disable iff (!rst_n)
    acq_s |=> !sout_valid);
  p_token_after_data_r8: assert property (@(posedge ro_clk) disable iff (!rst_n)
    token_out |-> !sout_valid);
  p_ptr_bound_r8: assert property (@(posedge ro_clk) disable iff (!rst_n)
    sout_valid |-> (rd_ptr < wr_cnt));
endmodule

// File: rtl/semi_digital_hitmem.sv
module semi_digital_hitmem #(
  parameter int NCH   = 64,
  parameter int DEPTH = 128,
  parameter int TSW   = 24,
  localparam int FW   = TSW + 2*NCH,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic           bx_clk,
  input  logic           ro_clk,
  input  logic           rst_n,
  input  logic           acq_on,
  input  logic [3*NCH-1:0] disc,
  input  logic           trig_valid,
  input  logic           token_in,
  input  logic           sout_ready,
  output logic           sout,
  output logic           sout_valid,
  output logic           token_out,
  output logic           mem_full
);
  logic [2*NCH-1:0] codes;
  logic [AW-1:0]    rd_addr;
  logic [FW-1:0]    rd_data;
  logic [CW-1:0]    wr_cnt;

  hm_encoder #(.NCH(NCH)) u_enc (.disc(disc), .codes(codes));

  hm_frame_store #(.NCH(NCH), .DEPTH(DEPTH), .TSW(TSW)) u_store (
    .bx_clk(bx_clk), .rst_n(rst_n), .acq_on(acq_on), .trig_valid(trig_valid),
    .codes(codes), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_cnt(wr_cnt), .mem_full(mem_full));

  hm_token_reader #(.FW(FW), .DEPTH(DEPTH)) u_rd (
    .ro_clk(ro_clk), .rst_n(rst_n), .acq_on(acq_on), .token_in(token_in),
    .sout_ready(sout_ready), .wr_cnt(wr_cnt), .rd_data(rd_data),
    .rd_addr(rd_addr), .sout(sout), .sout_valid(sout_valid),
    .token_out(token_out));
endmodule

// File: tb/test_semi_digital_hitmem.sv
`timescale 1ns/1ps
module test_semi_digital_hitmem;
  localparam int NCH = 64, DEPTH = 128, TSW = 10;
  localparam int FW = TSW + 2*NCH;

  logic bx_clk = 0, ro_clk = 0, rst_n = 0, acq_on = 0, trig_valid = 0;
  logic token_in = 0, sout_ready = 0;
  logic [3*NCH-1:0] disc = '0;
  logic sout, sout_valid, token_out, mem_full;

  always #2 bx_clk = ~bx_clk;
  always #3 ro_clk = ~ro_clk;

  semi_digital_hitmem #(.NCH(NCH), .DEPTH(DEPTH), .TSW(TSW)) i_semi_digital_hitmem (
    .bx_clk(bx_clk), .ro_clk(ro_clk), .rst_n(rst_n), .acq_on(acq_on), .disc(disc),
    .trig_valid(trig_valid), .token_in(token_in), .sout_ready(sout_ready),
    .sout(sout), .sout_valid(sout_valid), .token_out(token_out), .mem_full(mem_full));

  int n_cmp = 0, n_bad = 0;
  int ts_exp = 0, stored = 0, frames_rx = 0, tok_done = 0;
  logic [FW-1:0] q[$];

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2*NCH-1:0] model_codes(input logic [3*NCH-1:0] d);
    logic [2*NCH-1:0] r;
    for (int c = 0; c < NCH; c++)
      r[2*c +: 2] = d[3*c+2] ? 2'd3 : d[3*c+1] ? 2'd2 : d[3*c] ? 2'd1 : 2'd0;
    return r;
  endfunction

  function automatic logic [3*NCH-1:0] rand_disc();
    logic [3*NCH-1:0] r;
    for (int w = 0; w < 3*NCH; w += 32) r[w +: 32] = $urandom;
    return r;
  endfunction

  // driver: one bunch crossing, pushes the expected frame
  task automatic bx_cycle(input bit trig, input logic [3*NCH-1:0] d);
    disc = d;
    trig_valid = trig;
    if (trig && acq_on && stored < DEPTH) begin
      q.push_back({TSW'(ts_exp % (1 << TSW)), model_codes(d)});
      stored++;
    end
    @(posedge bx_clk);
    if (acq_on) ts_exp++;
    @(negedge bx_clk);
  endtask

  task automatic open_window();
    @(negedge bx_clk);
    acq_on = 1; ts_exp = 0; stored = 0;
  endtask

  task automatic close_window();
    acq_on = 0; trig_valid = 0;
    repeat (6) @(negedge ro_clk);
  endtask

  task automatic pass_token();
    @(negedge ro_clk); token_in = 1;
    @(negedge ro_clk); token_in = 0;
  endtask

  // monitor: consumer with random back-pressure, compares frames
  logic [FW-1:0] cur = '0;
  int nb = 0;
  bit tok_due = 0;
  initial begin
    forever begin
      bit rdy;
      @(negedge ro_clk);
      if (tok_due) begin
        chk(token_out === 1'b1, "R8 token after last bit", FW'(token_out), FW'(1));
        tok_due = 0;
        tok_done++;
      end
      rdy = ($urandom_range(0, 3) != 0);
      sout_ready = rdy;
      if (sout_valid && rdy) begin
        cur = {cur[FW-2:0], sout};
        nb++;
        if (nb == FW) begin
          nb = 0;
          frames_rx++;
          if (q.size() == 0) chk(1'b0, "R8 unexpected frame", cur, '0);
          else begin
            logic [FW-1:0] e;
            e = q.pop_front();
            chk(cur === e, "R1 R2 R3 R7 frame", cur, e);
            if (q.size() == 0) tok_due = 1;
          end
        end
      end
    end
  end

  task automatic drain(input int n_expect);
    int t0, f0;
    t0 = tok_done; f0 = frames_rx;
    pass_token();
    for (int i = 0; i < 60000 && tok_done == t0; i++) @(negedge ro_clk);
    chk(tok_done != t0, "R8 token returned", FW'(tok_done - t0), FW'(1));
    chk(frames_rx - f0 == n_expect, "R4 frame count", FW'(frames_rx - f0), FW'(n_expect));
  endtask

  task automatic empty_token();
    @(negedge ro_clk); token_in = 1;
    @(negedge ro_clk); token_in = 0;
    chk(token_out === 1'b1 && sout_valid === 1'b0, "R9 empty chip passes token",
        FW'({token_out, sout_valid}), FW'(2'b10));
    @(negedge ro_clk);
    chk(token_out === 1'b0, "R9 token is one cycle", FW'(token_out), FW'(0));
  endtask

  initial begin
    #760000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge bx_clk);
    chk({sout_valid, token_out, mem_full} === 3'b000, "R10 reset outputs",
        FW'({sout_valid, token_out, mem_full}), '0);
    rst_n = 1;
    repeat (3) @(negedge ro_clk);
    empty_token();

    // trigger in idle gap must not store (R4)
    @(negedge bx_clk);
    bx_cycle(1, rand_disc());

    // window 1: every level pattern, gaps in triggers
    open_window();
    for (int i = 0; i < 24; i++) begin
      logic [3*NCH-1:0] d;
      for (int c = 0; c < NCH; c++) d[3*c +: 3] = 3'((c + i) % 8);
      if (i >= 8) d = rand_disc();
      bx_cycle(i % 3 != 2, d);
    end
    chk(mem_full === 1'b0, "R5 not full", FW'(mem_full), '0);
    // token during the window is ignored (R6)
    pass_token();
    for (int k = 0; k < 3; k++) begin
      chk(sout_valid === 1'b0 && token_out === 1'b0, "R6 quiet in window",
          FW'({sout_valid, token_out}), '0);
      @(negedge ro_clk);
    end
    @(negedge bx_clk);
    close_window();
    @(negedge bx_clk);
    bx_cycle(1, rand_disc());
    drain(16);
    empty_token();

    // window 2: timestamp wrap and fill to full
    open_window();
    for (int i = 0; i < 127; i++) bx_cycle(1, rand_disc());
    chk(mem_full === 1'b0, "R5 127 frames not full", FW'(mem_full), '0);
    while (ts_exp < 1030) bx_cycle(0, rand_disc());
    bx_cycle(1, rand_disc());
    chk(mem_full === 1'b1, "R5 full at 128", FW'(mem_full), FW'(1));
    bx_cycle(1, rand_disc());
    bx_cycle(1, rand_disc());
    chk(mem_full === 1'b1, "R5 stays full", FW'(mem_full), FW'(1));
    close_window();
    drain(128);
    empty_token();

    // window 3: count restarts
    open_window();
    bx_cycle(0, '0);
    chk(mem_full === 1'b0, "R4 full cleared on new window", FW'(mem_full), '0);
    bx_cycle(1, {NCH{3'b101}});
    close_window();
    drain(1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule